// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block writes a byte image into an erased parallel EPROM. Starting from the lowest address and working upward, it fetches each image byte from a request/valid source. It sets up the address and data lines and raises the supply-select enables. It then fires timed active-low chip-enable program pulses. After every pulse it drops the programming voltage and reads the byte back. A matching byte moves the sequencer to the next address. A mismatch triggers another pulse, up to a hard cap on pulses per address. If the cap is reached without a match, the run aborts with a failure.

Once every address is programmed, the sequencer lowers VCC to its nominal verify level and fetches the image a second time. It re-reads each location and compares it. The run ends at the first mismatch, which is reported with its address, or ends with a pass. Bytes equal to all ones are already in the erased state and skip the pulse loop. Pulse width is counted in clock cycles derived from a clock-frequency parameter. The read data-valid wait, the setup time and the supply settle time are cycle parameters.

The state machine has thirteen states. IDLE waits for start and goes to VCC_UP. VCC_UP raises VCC, settles and goes to FETCH. FETCH takes an image byte. It goes to SETUP, or to ADVANCE for an all-ones byte. SETUP turns on VPP and drives the data bus, then goes to PULSE. PULSE holds chip-enable low, then goes to RECOVER. RECOVER drops VPP and releases the bus, then goes to VERIFY. VERIFY performs a read and goes to ADVANCE on a match. On a mismatch it goes back to SETUP, or to FINISH when the cap has been reached. ADVANCE steps the address. After the last address it goes to VCC_DOWN, otherwise back to FETCH. VCC_DOWN drops VCC to nominal and goes to CMP_FETCH. CMP_FETCH takes an image byte and goes to CMP_READ. CMP_READ reads the location and compares it. A mismatch goes to FINISH; a match goes to CMP_ADVANCE. CMP_ADVANCE steps the address. After the last address it goes to FINISH, otherwise to CMP_FETCH. FINISH holds the result and goes back to VCC_UP on a new start.

Top module: `eprom_burner`

## Requirements
- R1: After reset, rom_ce_n=1, rom_oe_n=1, vpp_en=0, vcc_raise=0, rom_dout_en=0, img_req=0, busy=0 and done=0.
- R2: Each program pulse holds rom_ce_n low with rom_oe_n high for exactly CLK_HZ*PULSE_US/1e6 cycles. Throughout the pulse, vpp_en=1 and rom_dout_en=1, and rom_addr and rom_dout do not change.
- R3: Every read-back holds rom_ce_n=0 and rom_oe_n=0 with vpp_en=0 and rom_dout_en=0. rom_din is sampled exactly DV_CYC cycles after rom_ce_n falls.
- R4: After a pulse whose read-back differs from the image byte, another pulse follows at the same address. A match ends pulsing for that address, so an address needing k pulses (k at most MAX_PULSES) receives exactly k.
- R5: No address receives more than MAX_PULSES pulses. A match on the last allowed pulse counts as success. With no match by then, the run finishes with pass=0 and fail_addr set to that address, and no further address is fetched.
- R6: Image bytes are requested in ascending address order, starting at 0, with img_addr equal to the address. A byte is taken on a cycle where img_req and img_valid are both high. Each address is fully programmed before the next is requested.
- R7: An image byte of 8'hFF produces no program pulse at its address.
- R8: vpp_en is high only while vcc_raise is high.
- R9: After programming, the image is fetched again from address 0. Each location is read with vcc_raise=0 and vpp_en=0 and compared with its image byte. The first mismatch ends the run with pass=0 and fail_addr set to that address. If every byte matches, the run ends with pass=1.
- R10: busy is high from the edge that accepts start until the run ends. done then stays high with pass and fail_addr held until the next start. A start while busy has no effect.
- R11: While busy is low, rom_ce_n=1, vpp_en=0 and vcc_raise=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled in IDLE or FINISH) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | 1 when every byte programmed and compared |
| fail_addr | output | ADDR_W | Address of the failing location |
| img_req | output | 1 | Image byte requested |
| img_addr | output | ADDR_W | Address of the requested image byte |
| img_valid | input | 1 | Image byte present on img_data |
| img_data | input | DATA_W | Image byte |
| rom_addr | output | ADDR_W | Device address lines |
| rom_dout | output | DATA_W | Data driven to the device while programming |
| rom_dout_en | output | 1 | Drive enable for rom_dout |
| rom_din | input | DATA_W | Data read from the device |
| rom_ce_n | output | 1 | Active-low chip enable / program pulse |
| rom_oe_n | output | 1 | Active-low output enable (logic level of OE/VPP pin) |
| vpp_en | output | 1 | Selects programming voltage on the OE/VPP pin |
| vcc_raise | output | 1 | Selects raised VCC (1) or nominal verify VCC (0) |

## Verification
The same-cycle collision that matters is in the last cycle of VERIFY. The pulse-cap limit and a successful read-back can be true at the same moment. A match must win, and the address must count as programmed. The bench provokes this with an address whose device model needs exactly the cap number of pulses, expecting a pass. A neighbouring case needs one pulse more, expecting a failure at that address with exactly the cap number of pulses seen. The pulse count, the fetch sequence and the final result all judge both cases.

// File: rtl/eprom_burner_pkg.sv
package eprom_burner_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC_UP,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_RECOVER,
        ST_VERIFY,
        ST_ADVANCE,
        ST_VCC_DOWN,
        ST_CMP_FETCH,
        ST_CMP_READ,
        ST_CMP_ADVANCE,
        ST_FINISH
    } burn_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic vpp_en;
        logic vcc_raise;
        logic bus_drive;
        logic img_req;
        logic busy;
        logic done;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, vpp_en: 1'b0,
                                    vcc_raise: 1'b0, bus_drive: 1'b0,
                                    img_req: 1'b0, busy: 1'b0, done: 1'b0};

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for the state the machine is about to occupy.
    function automatic pins_t decode_pins(burn_state_e s);
        pins_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, vpp_en: 1'b0, vcc_raise: 1'b0,
              bus_drive: 1'b0, img_req: 1'b0, busy: 1'b1, done: 1'b0};
        unique case (s)
            ST_IDLE:   p.busy = 1'b0;
            ST_FINISH: begin
                p.busy = 1'b0;
                p.done = 1'b1;
            end
            ST_VCC_UP, ST_ADVANCE, ST_RECOVER: p.vcc_raise = 1'b1;
            ST_FETCH: begin
                p.vcc_raise = 1'b1;
                p.img_req   = 1'b1;
            end
            ST_SETUP: begin
                p.vcc_raise = 1'b1;
                p.vpp_en    = 1'b1;
                p.bus_drive = 1'b1;
            end
            ST_PULSE: begin
                p.vcc_raise = 1'b1;
                p.vpp_en    = 1'b1;
                p.bus_drive = 1'b1;
                p.ce_n      = 1'b0;
            end
            ST_VERIFY: begin
                p.vcc_raise = 1'b1;
                p.ce_n      = 1'b0;
                p.oe_n      = 1'b0;
            end
            ST_VCC_DOWN, ST_CMP_ADVANCE: p.busy = 1'b1;
            ST_CMP_FETCH: p.img_req = 1'b1;
            ST_CMP_READ: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            default: p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/epb_timer.sv
module epb_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/epb_attempts.sv
module epb_attempts #(
    parameter int MAX_PULSES = 25,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             at_cap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (bump && !at_cap) begin
            count <= count + 1'b1;
        end
    end

    assign at_cap = (count == CNT_W'(MAX_PULSES));
endmodule

// File: rtl/epb_addr_seq.sv
module epb_addr_seq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == {ADDR_W{1'b1}});
endmodule

// File: rtl/eprom_burner.sv
module eprom_burner
    import eprom_burner_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int CLK_HZ      = 100_000_000,
    parameter int PULSE_US    = 100,
    parameter int MAX_PULSES  = 25,
    parameter int DV_CYC      = 10,
    parameter int SETUP_CYC   = 4,
    parameter int SETTLE_CYC  = 16,
    parameter int SKIP_ERASED = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              img_req,
    output logic [ADDR_W-1:0] img_addr,
    input  logic              img_valid,
    input  logic [DATA_W-1:0] img_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rom_dout,
    output logic              rom_dout_en,
    input  logic [DATA_W-1:0] rom_din,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              vpp_en,
    output logic              vcc_raise
);
    localparam int PULSE_RAW = int'((64'(CLK_HZ) * 64'(PULSE_US)) / 64'd1_000_000);
    localparam int PULSE_CYC = max2(PULSE_RAW, 1);
    localparam int LONGEST   = max2(max2(PULSE_CYC, SETTLE_CYC), max2(SETUP_CYC, DV_CYC));
    localparam int TMR_W     = $clog2(LONGEST + 1);
    localparam int CNT_W     = $clog2(MAX_PULSES + 1);

    burn_state_e       state, state_nxt;
    pins_t             pins_q;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  pulse_cnt;
    logic              at_cap, cnt_clear, cnt_bump;
    logic [ADDR_W-1:0] addr;
    logic              at_last, addr_clear, addr_step;
    logic [DATA_W-1:0] img_byte;
    logic              pass_q;
    logic [ADDR_W-1:0] fail_q;
    logic              byte_match, run_start, erased_byte;

    assign byte_match  = (rom_din == img_byte);
    assign run_start   = ((state == ST_IDLE) || (state == ST_FINISH)) && start;
    assign erased_byte = (SKIP_ERASED != 0) && (img_data == {DATA_W{1'b1}});

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_FINISH: if (start) state_nxt = ST_VCC_UP;
            ST_VCC_UP:   if (tmr_done) state_nxt = ST_FETCH;
            ST_FETCH:    if (img_valid) state_nxt = erased_byte ? ST_ADVANCE : ST_SETUP;
            ST_SETUP:    if (tmr_done) state_nxt = ST_PULSE;
            ST_PULSE:    if (tmr_done) state_nxt = ST_RECOVER;
            ST_RECOVER:  if (tmr_done) state_nxt = ST_VERIFY;
            ST_VERIFY: begin
                if (tmr_done) begin
                    if (byte_match)  state_nxt = ST_ADVANCE;
                    else if (at_cap) state_nxt = ST_FINISH;
                    else             state_nxt = ST_SETUP;
                end
            end
            ST_ADVANCE:     state_nxt = at_last ? ST_VCC_DOWN : ST_FETCH;
            ST_VCC_DOWN:    if (tmr_done) state_nxt = ST_CMP_FETCH;
            ST_CMP_FETCH:   if (img_valid) state_nxt = ST_CMP_READ;
            ST_CMP_READ:    if (tmr_done) state_nxt = byte_match ? ST_CMP_ADVANCE : ST_FINISH;
            ST_CMP_ADVANCE: state_nxt = at_last ? ST_FINISH : ST_CMP_FETCH;
            default:        state_nxt = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // ---------------- output register (decoded from next state) ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= PINS_IDLE;
        else        pins_q <= decode_pins(state_nxt);
    end

    // ---------------- dwell time per state ----------------
    assign tmr_load = (state_nxt != state);

    always_comb begin
        unique case (state_nxt)
            ST_VCC_UP, ST_VCC_DOWN:  tmr_val = TMR_W'(SETTLE_CYC - 1);
            ST_SETUP, ST_RECOVER:    tmr_val = TMR_W'(SETUP_CYC - 1);
            ST_PULSE:                tmr_val = TMR_W'(PULSE_CYC - 1);
            ST_VERIFY, ST_CMP_READ:  tmr_val = TMR_W'(DV_CYC - 1);
            default:                 tmr_val = '0;
        endcase
    end

    epb_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign cnt_clear = (state == ST_FETCH);
    assign cnt_bump  = (state_nxt == ST_PULSE) && (state != ST_PULSE);

    epb_attempts #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) u_attempts (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .bump   (cnt_bump),
        .count  (pulse_cnt),
        .at_cap (at_cap)
    );

    assign addr_clear = run_start || ((state == ST_VCC_DOWN) && tmr_done);
    assign addr_step  = ((state == ST_ADVANCE) || (state == ST_CMP_ADVANCE)) && !at_last;

    epb_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (addr_clear),
        .step    (addr_step),
        .addr    (addr),
        .at_last (at_last)
    );

    // ---------------- byte holding and result ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_byte <= '0;
            pass_q   <= 1'b0;
            fail_q   <= '0;
        end else begin
            if (((state == ST_FETCH) || (state == ST_CMP_FETCH)) && img_valid)
                img_byte <= img_data;
            if (run_start) begin
                pass_q <= 1'b0;
                fail_q <= '0;
            end
            if ((state == ST_VERIFY) && tmr_done && !byte_match && at_cap)
                fail_q <= addr;
            if ((state == ST_CMP_READ) && tmr_done && !byte_match)
                fail_q <= addr;
            if ((state == ST_CMP_ADVANCE) && at_last)
                pass_q <= 1'b1;
        end
    end

    assign busy        = pins_q.busy;
    assign done        = pins_q.done;
    assign pass        = pass_q;
    assign fail_addr   = fail_q;
    assign img_req     = pins_q.img_req;
    assign img_addr    = addr;
    assign rom_addr    = addr;
    assign rom_dout    = img_byte;
    assign rom_dout_en = pins_q.bus_drive;
    assign rom_ce_n    = pins_q.ce_n;
    assign rom_oe_n    = pins_q.oe_n;
    assign vpp_en      = pins_q.vpp_en;
    assign vcc_raise   = pins_q.vcc_raise;
endmodule

// File: rtl/eprom_burner_chk.sv
module eprom_burner_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int MAX_PULSES = 25,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              vpp_en,
    input logic              vcc_raise,
    input logic              rom_dout_en,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [DATA_W-1:0] rom_dout,
    input logic [CNT_W-1:0]  pulse_cnt
);
    // R8: VPP is only requested while VCC is raised
    a_r8_vpp_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> vcc_raise);

    // R2: a program pulse carries VPP and a driven bus
    a_r2_pulse_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && rom_oe_n) |-> (vpp_en && rom_dout_en));

    // R2: address and data stay put while the pulse lasts
    a_r2_pulse_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && rom_oe_n && !$past(rom_ce_n)) |-> ($stable(rom_addr) && $stable(rom_dout)));

    // R3: read-back happens with VPP off and the bus released
    a_r3_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !rom_oe_n) |-> (!vpp_en && !rom_dout_en));

    // R11: no enables asserted outside a run
    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rom_ce_n && !vpp_en && !vcc_raise));

    // R10: done and busy never overlap; done holds until start
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R5: pulse count never passes the cap
    a_r5_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pulse_cnt) <= MAX_PULSES);
endmodule

bind eprom_burner eprom_burner_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_PULSES (MAX_PULSES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .rom_ce_n    (rom_ce_n),
    .rom_oe_n    (rom_oe_n),
    .vpp_en      (vpp_en),
    .vcc_raise   (vcc_raise),
    .rom_dout_en (rom_dout_en),
    .rom_addr    (rom_addr),
    .rom_dout    (rom_dout),
    .pulse_cnt   (pulse_cnt)
);

// File: tb/eprom_burner_bench.sv
module eprom_burner_bench;
    localparam int AW      = 4;
    localparam int DEPTH   = 1 << AW;
    localparam int CLKHZ   = 40_000;
    localparam int PUS     = 100;
    localparam int PULSE_C = CLKHZ / 10_000 * PUS / 100;  // 4 cycles
    localparam int MAXP    = 25;
    localparam int DV      = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic          img_req;
    logic [AW-1:0] img_addr;
    logic          img_valid = 1'b0;
    logic [7:0]    img_data = 8'h00;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_dout;
    logic          rom_dout_en;
    logic [7:0]    rom_din = 8'h00;
    logic          rom_ce_n, rom_oe_n, vpp_en, vcc_raise;

    always #2 clk = ~clk;

    eprom_burner #(
        .ADDR_W(AW), .DATA_W(8), .CLK_HZ(CLKHZ), .PULSE_US(PUS),
        .MAX_PULSES(MAXP), .DV_CYC(DV), .SETUP_CYC(2), .SETTLE_CYC(5),
        .SKIP_ERASED(1)
    ) u_eprom_burner (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .img_req(img_req),
        .img_addr(img_addr), .img_valid(img_valid), .img_data(img_data),
        .rom_addr(rom_addr), .rom_dout(rom_dout), .rom_dout_en(rom_dout_en),
        .rom_din(rom_din), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .vpp_en(vpp_en), .vcc_raise(vcc_raise)
    );

    int checks = 0;
    int failures = 0;

    logic [7:0] image [DEPTH];
    logic [7:0] mem   [DEPTH];
    int         need  [DEPTH];
    int         pulses[DEPTH];

    int pw_bad, stab_bad, rd_bad, sup_bad, fetch_bad, fetch_k, cmp_reads;
    int low_len, rd_cnt, lat;
    logic prev_ce_n = 1'b1;
    logic prev_pulse = 1'b0;
    logic [AW-1:0] p_addr;
    logic [7:0]    p_data;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device and image-source model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vpp_en && !vcc_raise) sup_bad++;
            // program pulse tracking
            if (!rom_ce_n && rom_oe_n) begin
                if (!prev_pulse) begin
                    p_addr  = rom_addr;
                    p_data  = rom_dout;
                    low_len = 1;
                end else begin
                    low_len++;
                    if (rom_addr != p_addr || rom_dout != p_data) stab_bad++;
                end
                if (!vpp_en || !rom_dout_en) pw_bad++;
            end else if (prev_pulse) begin
                if (low_len != PULSE_C) pw_bad++;
                pulses[p_addr]++;
                if (pulses[p_addr] == need[p_addr]) mem[p_addr] = mem[p_addr] & p_data;
            end
            prev_pulse = !rom_ce_n && rom_oe_n;
            prev_ce_n  = rom_ce_n;
            // reads
            if (!rom_ce_n && !rom_oe_n) begin
                rd_cnt++;
                if (rd_cnt == 1 && !vcc_raise) cmp_reads++;
                if (vpp_en || rom_dout_en) rd_bad++;
            end else begin
                rd_cnt = 0;
            end
            rom_din = (rd_cnt >= DV) ? mem[rom_addr] : ~mem[rom_addr];
            // image source
            if (img_valid) begin
                img_valid = 1'b0;
            end else if (img_req) begin
                if (lat == 0) begin
                    img_valid = 1'b1;
                    img_data  = image[img_addr];
                    if (int'(img_addr) != (fetch_k % DEPTH)) fetch_bad++;
                    fetch_k++;
                    lat = $urandom_range(0, 3);
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic run_case(input string name, input int corrupt);
        int exp_p[DEPTH];
        int exp_fail, exp_cmp, exp_fetch, bad_prog, bad_skip, guard;
        bit exp_pass, prog_fail;
        for (int a = 0; a < DEPTH; a++) begin
            mem[a] = 8'hFF;
            pulses[a] = 0;
            exp_p[a] = 0;
        end
        pw_bad = 0; stab_bad = 0; rd_bad = 0; sup_bad = 0;
        fetch_bad = 0; fetch_k = 0; cmp_reads = 0; lat = 0;
        exp_fail = -1; prog_fail = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            if (image[a] != 8'hFF) begin
                if (need[a] > MAXP) begin
                    exp_p[a] = MAXP;
                    exp_fail = a;
                    prog_fail = 1'b1;
                    break;
                end
                exp_p[a] = need[a];
            end
        end
        if (prog_fail) begin
            exp_cmp = 0;
            exp_fetch = exp_fail + 1;
            exp_pass = 1'b0;
        end else begin
            exp_cmp = (corrupt >= 0) ? corrupt + 1 : DEPTH;
            exp_fail = corrupt;
            exp_pass = (corrupt < 0);
            exp_fetch = DEPTH + exp_cmp;
        end
        if (corrupt >= 0) begin
            fork
                begin
                    wait (vcc_raise == 1'b1);
                    wait (vcc_raise == 1'b0);
                    mem[corrupt] = mem[corrupt] ^ 8'h10;
                end
            join_none
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, {"R10 busy after start ", name}, busy, 1);
        repeat (12) @(negedge clk);
        start = 1'b1;                      // R10: start while busy is ignored
        @(negedge clk) start = 1'b0;
        guard = 0;
        while (!done && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        chk(done && !busy, {"R10 done held ", name}, done, 1);
        chk(pass == exp_pass, {"R5,R9 pass ", name}, pass, exp_pass);
        if (!exp_pass)
            chk(int'(fail_addr) == exp_fail, {"R5,R9 fail_addr ", name}, fail_addr, exp_fail);
        bad_prog = 0; bad_skip = 0;
        for (int a = 0; a < DEPTH; a++) begin
            if (image[a] == 8'hFF) begin
                if (pulses[a] != 0) bad_skip++;
            end else if (pulses[a] != exp_p[a]) begin
                bad_prog++;
            end
        end
        chk(bad_prog == 0, {"R4 pulses per address ", name}, bad_prog, 0);
        chk(bad_skip == 0, {"R7 erased bytes skipped ", name}, bad_skip, 0);
        chk(pw_bad == 0 && stab_bad == 0, {"R2 pulse shape ", name}, pw_bad + stab_bad, 0);
        chk(rd_bad == 0, {"R3 read conditions ", name}, rd_bad, 0);
        chk(sup_bad == 0, {"R8 supply order ", name}, sup_bad, 0);
        chk(fetch_bad == 0 && fetch_k == exp_fetch, {"R6 fetch order ", name}, fetch_k, exp_fetch);
        chk(cmp_reads == exp_cmp, {"R9 compare reads ", name}, cmp_reads, exp_cmp);
        chk(rom_ce_n && !vpp_en && !vcc_raise, {"R11 quiet when finished ", name},
            {rom_ce_n, vpp_en, vcc_raise}, 3'b100);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rom_ce_n && rom_oe_n && !vpp_en && !vcc_raise && !rom_dout_en &&
            !img_req && !busy && !done, "R1 reset state", 0, 1);

        for (int a = 0; a < DEPTH; a++) begin
            image[a] = 8'($urandom_range(0, 254));
            need[a] = 1;
        end
        image[3] = 8'hFF;
        run_case("single pulse", -1);

        for (int a = 0; a < DEPTH; a++) begin
            image[a] = 8'($urandom_range(0, 255));
            need[a] = $urandom_range(1, 6);
        end
        image[0] = 8'h00;
        image[15] = 8'hFF;
        run_case("random retries", -1);

        for (int a = 0; a < DEPTH; a++) need[a] = $urandom_range(1, 3);
        image[5] = 8'h3C;
        need[5] = MAXP;                    // R5: match on the last allowed pulse
        run_case("match at cap", -1);

        need[9] = MAXP + 1;                // R5: never matches
        image[9] = 8'h00;
        run_case("cap exceeded", -1);

        need[9] = 2;
        run_case("compare mismatch mid", 11);
        run_case("compare mismatch first", 0);
        run_case("compare mismatch last", 15);

        for (int a = 0; a < DEPTH; a++) image[a] = 8'hFF;
        run_case("all erased", -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule